// File: doc/BRIEF.md
# Card clock update controller

This block produces the card clock for a memory-card host and lets software change that clock's rate, source and per-card enables without a runt pulse on any output. Software writes new divider, source and enable values into shadow registers. None of these values reaches the clock logic until software issues an update-only command word. An update-only command sends nothing on the card bus. Its only effect is to copy the shadow values into the live clock logic. The start bit of the command reads back as 1 until the block has taken the command, so software polls it to find out when the change is complete.

The clock sources reach the block as tick enables in the system clock domain. The selected source ticks a counter, and the counter toggles the internal card clock every `2N` ticks for a divider value of N, or every tick when the divider is 0. Each card output is that clock ANDed with a per-card gate. A gate changes state only while the clock is low.

A command can also ask to wait for the previous data transfer to finish. It is then not accepted while the registered data-busy status reads 1. The intended software order is:
1. Gate all cards off.
2. Change the divider and/or the source.
3. Gate the cards back on.

Each step is its own update command.

Top module: `cclk_update_ctrl`

## Requirements
- R1: After reset, every card output is low, the start readback is 0, the status word is 0, the hold select is 0, and the live divider, source and enables are all 0.
- R2: Writes to the shadow divider, source or enable registers do not change any card output until an update command is accepted.
- R3: A command write with bit 31 (start) and bit 21 (update clock only) both set makes the start readback 1 after the next clock edge. Without bit 13 (wait for data), the command is accepted on the following edge: the start readback returns to 0 and the shadow values become live.
- R4: When bit 13 of the command is set, acceptance is held off while status bit 9 reads 1. The command is accepted on the first edge at which status bit 9 reads 0.
- R5: Status bit 9 equals the `data_active` input delayed by one clock. All other status bits read 0.
- R6: A command with bit 31 set but bit 21 clear is ignored: the start readback stays 0 and the hold select and the card clocks do not change.
- R7: A command written while an earlier one is still pending is ignored. It is neither queued nor accepted later.
- R8: The hold select output takes the value of command bit 29 only when that command is accepted, and holds it otherwise.
- R9: With divider value 0, the card clock toggles on every tick of the selected source. With value N > 0, it toggles every 2N ticks.
- R10: The live source value chooses which `src_tick` bit drives the divider. The card clock changes only on a tick of that source.
- R11: Each card output follows the card clock while its live enable bit is 1 and stays low while it is 0. A gate changes state only when the card clock was low in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC | One tick enable per clock source |
| div_wr | input | 1 | Write strobe for the shadow divider |
| div_wdata | input | DIV_W | New divider value |
| src_wr | input | 1 | Write strobe for the shadow source select |
| src_wdata | input | $clog2(NUM_SRC) | New source index |
| en_wr | input | 1 | Write strobe for the shadow card enables |
| en_wdata | input | NUM_CARDS | New per-card enables |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word (start 31, hold 29, update-only 21, wait-for-data 13) |
| data_active | input | 1 | A data transfer is in progress |
| cmd_start_o | output | 1 | Start bit readback: 1 while a command is pending |
| status_o | output | 16 | Status word, bit 9 = data busy |
| hold_sel_o | output | 1 | Transmit-path hold register select |
| cclk_out | output | NUM_CARDS | Gated card clock outputs |

## Verification
The bench builds the block with two sources, a 4-bit divider and two cards. One source ticks every cycle and the other every third cycle, so a change of source shows up directly as a threefold change in the measured period. The 4-bit divider keeps even the slowest settings used within a few dozen cycles per period. Two cards make it possible to show that one gate closes while its neighbour keeps running. A data-busy phase long enough to hold a wait-flagged command, with a second command written into that window, brings the ignore-while-pending rule and the one-cycle status delay within reach.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
    localparam int CMD_W            = 32;
    localparam int STAT_W           = 16;
    localparam int CMD_START_BIT    = 31;
    localparam int CMD_HOLD_BIT     = 29;
    localparam int CMD_CLKONLY_BIT  = 21;
    localparam int CMD_WAITDATA_BIT = 13;
    localparam int STAT_BUSY_BIT    = 9;
endpackage

// File: rtl/cclk_cmd_ctrl.sv
module cclk_cmd_ctrl
    import cclk_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SRC_W     = 2,
    parameter int NUM_CARDS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 div_wr,
    input  logic [DIV_W-1:0]     div_wdata,
    input  logic                 src_wr,
    input  logic [SRC_W-1:0]     src_wdata,
    input  logic                 en_wr,
    input  logic [NUM_CARDS-1:0] en_wdata,
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_wdata,
    input  logic                 data_active,
    output logic                 start_pending,
    output logic                 busy,
    output logic                 hold_sel,
    output logic [DIV_W-1:0]     live_div,
    output logic [SRC_W-1:0]     live_src,
    output logic [NUM_CARDS-1:0] live_en,
    output logic                 restart
);
    typedef struct packed {
        logic [DIV_W-1:0]     sh_div;
        logic [SRC_W-1:0]     sh_src;
        logic [NUM_CARDS-1:0] sh_en;
        logic [DIV_W-1:0]     lv_div;
        logic [SRC_W-1:0]     lv_src;
        logic [NUM_CARDS-1:0] lv_en;
        logic                 pending;
        logic                 wait_data;
        logic                 hold_req;
        logic                 hold;
        logic                 busy;
        logic                 restart;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  accept;
    logic  cmd_req;
    logic  cmd_unused;

    // Only a few bits of the command word matter; the rest are reduced away.
    assign cmd_unused = ^cmd_wdata;

    always_comb begin
        ctrl_d  = ctrl_q;
        cmd_req = cmd_wr && cmd_wdata[CMD_START_BIT] && cmd_wdata[CMD_CLKONLY_BIT];
        accept  = ctrl_q.pending && (!ctrl_q.wait_data || !ctrl_q.busy);

        ctrl_d.busy    = data_active;
        ctrl_d.restart = accept;

        if (div_wr) ctrl_d.sh_div = div_wdata;
        if (src_wr) ctrl_d.sh_src = src_wdata;
        if (en_wr)  ctrl_d.sh_en  = en_wdata;

        if (accept) begin
            // Copy from the registered shadows, so a write in this cycle waits.
            ctrl_d.lv_div  = ctrl_q.sh_div;
            ctrl_d.lv_src  = ctrl_q.sh_src;
            ctrl_d.lv_en   = ctrl_q.sh_en;
            ctrl_d.hold    = ctrl_q.hold_req;
            ctrl_d.pending = 1'b0;
        end else if (!ctrl_q.pending && cmd_req) begin
            ctrl_d.pending   = 1'b1;
            ctrl_d.wait_data = cmd_wdata[CMD_WAITDATA_BIT];
            ctrl_d.hold_req  = cmd_wdata[CMD_HOLD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign start_pending = ctrl_q.pending;
    assign busy          = ctrl_q.busy;
    assign hold_sel      = ctrl_q.hold;
    assign live_div      = ctrl_q.lv_div;
    assign live_src      = ctrl_q.lv_src;
    assign live_en       = ctrl_q.lv_en;
    assign restart       = ctrl_q.restart;

    // R3: a request without the wait flag is taken one cycle after it is seen.
    assert_nowait_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.pending && !ctrl_q.wait_data) |=> !ctrl_q.pending);

    // R4: a waiting request stays pending while the data path is busy.
    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.pending && ctrl_q.wait_data && ctrl_q.busy) |=> ctrl_q.pending);

    // R2: the live settings move only on acceptance.
    assert_live_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(ctrl_q.lv_div) && $stable(ctrl_q.lv_src) && $stable(ctrl_q.lv_en)));

    // R8: the hold select moves only on acceptance.
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(ctrl_q.hold));
endmodule

// File: rtl/cclk_divider.sv
module cclk_divider #(
    parameter int DIV_W   = 8,
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SRC_W-1:0]   sel,
    input  logic [DIV_W-1:0]   div,
    input  logic               restart,
    output logic               cclk
);
    localparam int               CNT_W   = DIV_W + 1;
    localparam logic [SRC_W:0]   SRC_CNT = (SRC_W + 1)'(NUM_SRC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cclk;
    } div_t;

    div_t             div_d, div_q;
    logic             tick;
    logic [CNT_W-1:0] limit;

    always_comb begin
        div_d = div_q;
        tick  = ({1'b0, sel} < SRC_CNT) ? src_tick[sel] : 1'b0;
        // Half period in source ticks: 1 for a zero divider, else twice the divider.
        limit = (div == '0) ? CNT_W'(1) : {div, 1'b0};
        if (restart) begin
            div_d.cnt = '0;
        end else if (tick) begin
            if (div_q.cnt >= limit - 1'b1) begin
                div_d.cnt  = '0;
                div_d.cclk = ~div_q.cclk;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign cclk = div_q.cclk;

    // R10: without a tick of the selected source the card clock holds.
    assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(div_q.cclk));

    // R9: a restart clears the tick count and leaves the clock level alone.
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q.cnt == '0) && $stable(div_q.cclk));
endmodule

// File: rtl/cclk_gate.sv
module cclk_gate #(
    parameter int NUM_CARDS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cclk,
    input  logic [NUM_CARDS-1:0] en,
    output logic [NUM_CARDS-1:0] cclk_out
);
    logic [NUM_CARDS-1:0] gate_d, gate_q;

    // Gates follow their enables only in the low phase of the card clock.
    always_comb begin
        gate_d = cclk ? gate_q : en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    for (genvar g = 0; g < NUM_CARDS; g++) begin : g_card
        assign cclk_out[g] = cclk & gate_q[g];

        // R11: a gate edge never lands inside a high phase.
        assert_gate_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(gate_q[g]) |-> !$past(cclk));
    end
endmodule

// File: rtl/cclk_update_ctrl.sv
module cclk_update_ctrl
    import cclk_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int DIV_W     = 8,
    parameter int NUM_CARDS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_tick,
    input  logic                       div_wr,
    input  logic [DIV_W-1:0]           div_wdata,
    input  logic                       src_wr,
    input  logic [$clog2(NUM_SRC)-1:0] src_wdata,
    input  logic                       en_wr,
    input  logic [NUM_CARDS-1:0]       en_wdata,
    input  logic                       cmd_wr,
    input  logic [31:0]                cmd_wdata,
    input  logic                       data_active,
    output logic                       cmd_start_o,
    output logic [15:0]                status_o,
    output logic                       hold_sel_o,
    output logic [NUM_CARDS-1:0]       cclk_out
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic                 busy;
    logic                 restart;
    logic                 cclk;
    logic [DIV_W-1:0]     live_div;
    logic [SRC_W-1:0]     live_src;
    logic [NUM_CARDS-1:0] live_en;

    cclk_cmd_ctrl #(
        .DIV_W     (DIV_W),
        .SRC_W     (SRC_W),
        .NUM_CARDS (NUM_CARDS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_wr        (div_wr),
        .div_wdata     (div_wdata),
        .src_wr        (src_wr),
        .src_wdata     (src_wdata),
        .en_wr         (en_wr),
        .en_wdata      (en_wdata),
        .cmd_wr        (cmd_wr),
        .cmd_wdata     (cmd_wdata),
        .data_active   (data_active),
        .start_pending (cmd_start_o),
        .busy          (busy),
        .hold_sel      (hold_sel_o),
        .live_div      (live_div),
        .live_src      (live_src),
        .live_en       (live_en),
        .restart       (restart)
    );

    cclk_divider #(
        .DIV_W   (DIV_W),
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .sel      (live_src),
        .div      (live_div),
        .restart  (restart),
        .cclk     (cclk)
    );

    cclk_gate #(
        .NUM_CARDS (NUM_CARDS)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cclk     (cclk),
        .en       (live_en),
        .cclk_out (cclk_out)
    );

    always_comb begin
        status_o                = '0;
        status_o[STAT_BUSY_BIT] = busy;
    end

    // R5: the busy status trails the data path by one cycle.
    assert_busy_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[STAT_BUSY_BIT] == $past(data_active)));
endmodule

// File: tb/cclk_update_ctrl_tb_top.sv
`timescale 1ns/1ps
module cclk_update_ctrl_tb_top;
    import cclk_pkg::*;

    localparam int NUM_SRC   = 2;
    localparam int DIV_W     = 4;
    localparam int NUM_CARDS = 2;

    localparam logic [31:0] C_GO    = 32'h8020_0000;
    localparam logic [31:0] C_WAIT  = 32'h0000_2000;
    localparam logic [31:0] C_HOLD  = 32'h2000_0000;
    localparam logic [31:0] C_START = 32'h8000_0000;

    logic                 clk;
    logic                 rst_n;
    logic [NUM_SRC-1:0]   src_tick;
    logic                 div_wr;
    logic [DIV_W-1:0]     div_wdata;
    logic                 src_wr;
    logic [0:0]           src_wdata;
    logic                 en_wr;
    logic [NUM_CARDS-1:0] en_wdata;
    logic                 cmd_wr;
    logic [31:0]          cmd_wdata;
    logic                 data_active;
    logic                 cmd_start_o;
    logic [15:0]          status_o;
    logic                 hold_sel_o;
    logic [NUM_CARDS-1:0] cclk_out;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic exp_hold[$];

    cclk_update_ctrl #(
        .NUM_SRC   (NUM_SRC),
        .DIV_W     (DIV_W),
        .NUM_CARDS (NUM_CARDS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick    (src_tick),
        .div_wr      (div_wr),
        .div_wdata   (div_wdata),
        .src_wr      (src_wr),
        .src_wdata   (src_wdata),
        .en_wr       (en_wr),
        .en_wdata    (en_wdata),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (cmd_wdata),
        .data_active (data_active),
        .cmd_start_o (cmd_start_o),
        .status_o    (status_o),
        .hold_sel_o  (hold_sel_o),
        .cclk_out    (cclk_out)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Source 0 ticks every cycle, source 1 every third cycle.
    initial begin
        int ph;
        ph = 0;
        src_tick = 2'b01;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            src_tick = {ph == 0, 1'b1};
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Scoreboard monitor: every acceptance pops the expected hold value.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !cmd_start_o) begin
                if (exp_hold.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7 acceptance actual=1 expected=0");
                end else begin
                    logic e;
                    e = exp_hold.pop_front();
                    check("R8 hold on accept", 32'(hold_sel_o), 32'(e));
                end
            end
            prev = cmd_start_o;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic wr_div(input logic [DIV_W-1:0] v);
        @(negedge clk); div_wr = 1'b1; div_wdata = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic wr_src(input logic v);
        @(negedge clk); src_wr = 1'b1; src_wdata = v;
        @(negedge clk); src_wr = 1'b0;
    endtask

    task automatic wr_en(input logic [NUM_CARDS-1:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    // Driver: pushes the expected hold value when the command should be taken.
    task automatic issue(input logic [31:0] w, input bit will_accept);
        if (will_accept) exp_hold.push_back(w[CMD_HOLD_BIT]);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0;
    endtask

    task automatic wait_taken();
        for (int i = 0; i < 50; i++) begin
            if (!cmd_start_o) break;
            @(negedge clk);
        end
    endtask

    task automatic update(input logic [31:0] w);
        issue(w, 1'b1);
        wait_taken();
    endtask

    task automatic count_rises(input int c, input int n, output int r);
        logic prev;
        prev = cclk_out[c];
        r = 0;
        repeat (n) begin
            @(negedge clk);
            if (cclk_out[c] && !prev) r++;
            prev = cclk_out[c];
        end
    endtask

    task automatic measure(input int c, output int per);
        logic prev;
        prev = cclk_out[c];
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cclk_out[c] && !prev) break;
            prev = cclk_out[c];
        end
        per = 0;
        prev = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            per++;
            if (cclk_out[c] && !prev) break;
            prev = cclk_out[c];
        end
    endtask

    initial begin
        int r;
        int p;
        rst_n = 1'b0; div_wr = 0; div_wdata = '0; src_wr = 0; src_wdata = '0;
        en_wr = 0; en_wdata = '0; cmd_wr = 0; cmd_wdata = '0; data_active = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cclk_out", 32'(cclk_out), 0);
        check("R1 start", 32'(cmd_start_o), 0);
        check("R1 status", 32'(status_o), 0);
        check("R1 hold", 32'(hold_sel_o), 0);

        // R2: shadow writes alone leave the outputs low
        wr_div(4'd2);
        wr_en(2'b11);
        count_rises(0, 30, r);
        check("R2 card0 idle", 32'(r), 0);
        count_rises(1, 30, r);
        check("R2 card1 idle", 32'(r), 0);

        // R3: start readback and acceptance timing
        issue(C_GO, 1'b1);
        check("R3 start pending", 32'(cmd_start_o), 1);
        @(negedge clk);
        check("R3 start cleared", 32'(cmd_start_o), 0);

        // R9: divider 2 on source 0 gives period 8
        measure(0, p);
        check("R9 div2 card0 period", 32'(p), 8);
        measure(1, p);
        check("R9 div2 card1 period", 32'(p), 8);

        // R11: close card 1 only
        wr_en(2'b01);
        update(C_GO);
        repeat (4) @(negedge clk);
        count_rises(1, 40, r);
        check("R11 card1 gated", 32'(r), 0);
        check("R11 card1 low", 32'(cclk_out[1]), 0);
        measure(0, p);
        check("R11 card0 runs", 32'(p), 8);

        // R9: off, divider 0, on
        wr_en(2'b00);
        update(C_GO);
        wr_div(4'd0);
        update(C_GO);
        wr_en(2'b11);
        update(C_GO);
        measure(0, p);
        check("R9 div0 period", 32'(p), 2);

        // R10: off, source 1 with divider 3, on
        wr_en(2'b00);
        update(C_GO);
        wr_src(1'b1);
        wr_div(4'd3);
        update(C_GO);
        wr_en(2'b01);
        update(C_GO);
        measure(0, p);
        check("R10 src1 div3 period", 32'(p), 36);

        // back to source 0, divider 1
        wr_en(2'b00);
        update(C_GO);
        wr_src(1'b0);
        wr_div(4'd1);
        update(C_GO);
        wr_en(2'b01);
        update(C_GO);
        measure(0, p);
        check("R9 div1 period", 32'(p), 4);

        // R5: busy status follows data_active one cycle later
        @(negedge clk); data_active = 1'b1;
        check("R5 status before edge", 32'(status_o), 0);
        @(negedge clk);
        check("R5 status busy", 32'(status_o), 32'h0200);

        // R4: waiting command is held while busy
        issue(C_GO | C_WAIT | C_HOLD, 1'b1);
        repeat (8) @(negedge clk);
        check("R4 held while busy", 32'(cmd_start_o), 1);
        // R7: second command while pending is dropped
        issue(C_GO, 1'b0);
        check("R8 hold before accept", 32'(hold_sel_o), 0);
        data_active = 1'b0;
        @(negedge clk);
        check("R4 still pending", 32'(cmd_start_o), 1);
        check("R5 status clear", 32'(status_o), 0);
        @(negedge clk);
        check("R4 accepted", 32'(cmd_start_o), 0);
        check("R8 hold set", 32'(hold_sel_o), 1);
        repeat (6) @(negedge clk);
        check("R7 nothing queued", 32'(cmd_start_o), 0);
        check("R7 hold kept", 32'(hold_sel_o), 1);

        // R3: no wait flag, accepted even while busy
        @(negedge clk); data_active = 1'b1;
        issue(C_GO, 1'b1);
        check("R3 pending under busy", 32'(cmd_start_o), 1);
        @(negedge clk);
        check("R3 taken under busy", 32'(cmd_start_o), 0);
        check("R8 hold cleared", 32'(hold_sel_o), 0);
        data_active = 1'b0;

        // R6: start without the update flag is ignored
        wr_en(2'b00);
        issue(C_START | C_HOLD, 1'b0);
        check("R6 start ignored", 32'(cmd_start_o), 0);
        repeat (4) @(negedge clk);
        check("R6 hold unchanged", 32'(hold_sel_o), 0);
        count_rises(0, 30, r);
        check("R6 card0 still running", 32'(r > 0), 1);

        check("R8 scoreboard drained", 32'(exp_hold.size()), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule